// File: doc/BRIEF.md
# Serially Configured Clock Fan-Out Gate

This block fans one reference clock out to eighteen outputs. The outputs form four groups of four, which serve memory clocks, plus one pair of feedback outputs. Each output has an enable bit. When its bit is set, the output follows the reference clock. When its bit is clear, the output is held low. A separate output-enable pin sets the tri-state control of every output at once, so the whole fan-out can float for board test.

The enable bits are loaded over a standard-mode I2C bus. The block acts as a target that only receives. A controller addresses it with the write flag and then sends up to three configuration bytes. These bytes always fill configuration byte 0, then byte 1, then byte 2, in that order. There is no register address. The bus lines are sampled by the system clock through two-flop synchronizers, and the block acknowledges by pulling its data line low through an open-drain pull output.

Top module: `i2c_clk_fanout`

## Requirements
- R1: A byte whose upper seven bits are 1101001 and whose least significant bit (the direction flag) is 0 is acknowledged. The block asserts `sda_pull` while SCL is high during the ninth clock of that byte.
- R2: The block never asserts `sda_pull` for any of the following: an address with different upper bits, an address with the direction flag 1, or any of the eight data clocks of any byte. Bytes that follow an unacknowledged address leave every output unchanged.
- R3: The data bytes of one transaction load configuration byte 0, then byte 1, then byte 2. A new value reaches the outputs only after all eight bits of its byte have been received. Between writes, the enables hold their values.
- R4: Every data byte after an accepted address is acknowledged on its ninth clock. A fourth or later data byte in the same transaction is acknowledged but changes nothing.
- R5: A START, repeated START or STOP returns the load order to configuration byte 0.
- R6: After the synchronous reset `rst`, every enable bit is 1, so all outputs follow `ref_clk`.
- R7: Configuration byte 0 bits 3:0 enable `clk_out[3:0]` and bits 7:4 enable `clk_out[7:4]`. Byte 1 bits 7:0 enable `clk_out[15:8]` in the same order. Byte 2 bit 6 enables `clk_out[16]` and bit 7 enables `clk_out[17]`. Byte 2 bits 5:0 have no effect.
- R8: An enabled output equals `ref_clk`. A disabled output is 0 whatever `ref_clk` does.
- R9: When `outs_on` is 0, every `out_hiz` bit is 1 and every `clk_out` bit is 0, whatever the enables are. When `outs_on` is 1, every `out_hiz` bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | I2C clock line |
| sda_in | input | 1 | I2C data line as seen on the wire |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| ref_clk | input | 1 | Reference clock to be fanned out |
| outs_on | input | 1 | Global output enable; 0 floats every output |
| clk_out | output | 18 | Gated clock outputs |
| out_hiz | output | 18 | Per-output tri-state control, 1 = high impedance |

## Verification
The bench goes after three kinds of corner case. The first is where the write pointer sits. A fourth byte must not wrap onto byte 0. A repeated START and a STOP must both send the next byte back to byte 0; a design that kept the pointer would write the wrong group. The second is rejection. A read request and a foreign address must draw no acknowledge and must leave the enables alone; a design that decoded only the upper seven bits would take on settings meant for another target. The third is the output mapping. The reserved low bits of byte 2 are cleared while the feedback bits stay in effect, and the output-enable pin overrides the disabled outputs. Clock by clock, the gated outputs are compared against a behavioural register model.

// File: rtl/i2cfan_pkg.sv
package i2cfan_pkg;
  typedef enum logic [1:0] {
    TS_IDLE,
    TS_ADDR,
    TS_DATA,
    TS_SKIP
  } tgt_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      logic              last;
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe <= '1;
          last <= 1'b1;
        end else begin
          pipe <= {pipe[STAGES-2:0], d[g]};
          last <= pipe[STAGES-1];
        end
      end
      assign q[g]    = pipe[STAGES-1];
      assign rise[g] = pipe[STAGES-1] & ~last;
      assign fall[g] = ~pipe[STAGES-1] & last;
    end
  endgenerate
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2cfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         NREG     = 3,
  parameter int         PW       = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_q,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              sda_pull,
  output logic              wr_en,
  output logic [PW-1:0]     wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [3:0]    ACK_SLOT = 4'd8;
  localparam logic [PW-1:0] PTR_END  = PW'(NREG);

  tgt_state_e        state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [PW-1:0]     ptr;
  logic              ack_q;
  logic              bus_start, bus_stop, in_byte;

  assign bus_start = scl_q & ~scl_rise & sda_fall;
  assign bus_stop  = scl_q & ~scl_rise & sda_rise;
  assign in_byte   = (state == TS_ADDR) || (state == TS_DATA);

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state   <= TS_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      ack_q   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else if (bus_start) begin
      state  <= TS_ADDR;
      bitcnt <= '0;
      ptr    <= '0;
      ack_q  <= 1'b0;
    end else if (bus_stop) begin
      state  <= TS_IDLE;
      bitcnt <= '0;
      ptr    <= '0;
      ack_q  <= 1'b0;
    end else begin
      if (scl_rise && in_byte && bitcnt < ACK_SLOT) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_q};
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall && in_byte && bitcnt == ACK_SLOT) begin
        if (ack_q) begin
          ack_q  <= 1'b0;
          bitcnt <= '0;
          if (state == TS_ADDR) state <= TS_DATA;
        end else if (state == TS_ADDR) begin
          if (shreg[7:1] == DEV_ADDR && !shreg[0]) ack_q <= 1'b1;
          else                                     state <= TS_SKIP;
        end else begin
          ack_q <= 1'b1;
          if (ptr < PTR_END) begin
            wr_en   <= 1'b1;
            wr_idx  <= ptr;
            wr_data <= shreg;
            ptr     <= ptr + 1'b1;
          end
        end
      end
    end
  end

  assign sda_pull = ack_q;

  p_ack_slot_r4: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> (bitcnt == ACK_SLOT));
  p_skip_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (state == TS_SKIP) |-> !ack_q);
  p_ptr_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_start || bus_stop) |=> (ptr == '0));
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx < PTR_END - 1'b1) |-> (ptr == wr_idx + 1'b1));
endmodule

// File: rtl/enable_bank.sv
module enable_bank
  import i2cfan_pkg::*;
#(
  parameter int NGRP4 = 4,
  parameter int NFB   = 2,
  parameter int NREG  = 3,
  parameter int PW    = 2,
  parameter int NOUT  = 4 * NGRP4 + NFB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NOUT-1:0]   en_vec
);
  localparam int NGRPBITS = 4 * NGRP4;

  genvar i;
  generate
    for (i = 0; i < NOUT; i++) begin : g_bit
      localparam int RI = (i < NGRPBITS) ? (i / BYTE_W) : (NREG - 1);
      localparam int BI = (i < NGRPBITS) ? (i % BYTE_W) : (BYTE_W - NFB + i - NGRPBITS);
      always_ff @(posedge clk) begin
        if (rst)                                  en_vec[i] <= 1'b1;
        else if (wr_en && wr_idx == PW'(RI))      en_vec[i] <= wr_data[BI];
      end
    end
  endgenerate

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_vec));
endmodule

// File: rtl/i2c_clk_fanout.sv
module i2c_clk_fanout
  import i2cfan_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         NGRP4    = 4,
  parameter int         NFB      = 2,
  parameter int         STAGES   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_pull,
  input  logic                     ref_clk,
  input  logic                     outs_on,
  output logic [4*NGRP4+NFB-1:0]   clk_out,
  output logic [4*NGRP4+NFB-1:0]   out_hiz
);
  localparam int NOUT = 4 * NGRP4 + NFB;
  localparam int NREG = (NOUT + BYTE_W - 1) / BYTE_W;
  localparam int PW   = $clog2(NREG + 1);

  logic [1:0]        ln_q, ln_rise, ln_fall;
  logic              wr_en;
  logic [PW-1:0]     wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [NOUT-1:0]   en_vec;

  line_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({sda_in, scl_in}),
    .q(ln_q), .rise(ln_rise), .fall(ln_fall)
  );

  i2c_wr_target #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .PW(PW)) u_tgt (
    .clk(clk), .rst(rst),
    .scl_q(ln_q[0]), .scl_rise(ln_rise[0]), .scl_fall(ln_fall[0]),
    .sda_q(ln_q[1]), .sda_rise(ln_rise[1]), .sda_fall(ln_fall[1]),
    .sda_pull(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  enable_bank #(.NGRP4(NGRP4), .NFB(NFB), .NREG(NREG), .PW(PW), .NOUT(NOUT)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .en_vec(en_vec)
  );

  genvar i;
  generate
    for (i = 0; i < NOUT; i++) begin : g_gate
      assign clk_out[i] = outs_on & en_vec[i] & ref_clk;
      assign out_hiz[i] = ~outs_on;
      p_gate_low_r8: assert property (@(posedge clk) disable iff (rst)
        !en_vec[i] |-> !clk_out[i]);
    end
  endgenerate

  p_float_all_r9: assert property (@(posedge clk) disable iff (rst)
    !outs_on |-> (&out_hiz && clk_out == '0));
endmodule

// File: tb/tb_i2c_clk_fanout.sv
module tb_i2c_clk_fanout;
  localparam int Q = 8;
  localparam logic [7:0] A_WR  = 8'hD2;
  localparam logic [7:0] A_RD  = 8'hD3;
  localparam logic [7:0] A_BAD = 8'hA4;

  logic clk = 1'b0, rst = 1'b1, ref_clk = 1'b0, outs_on = 1'b1;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_pull;
  logic [17:0] clk_out, out_hiz;
  wire  sda_line = sda_drv & ~sda_pull;

  int checks = 0, errors = 0;
  bit settle = 1'b1, done = 1'b0;
  logic [7:0] m_reg [3];

  i2c_clk_fanout dut (
    .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_line), .sda_pull(sda_pull),
    .ref_clk(ref_clk), .outs_on(outs_on), .clk_out(clk_out), .out_hiz(out_hiz)
  );

  initial forever #5 clk = ~clk;
  initial begin #3; forever #8 ref_clk = ~ref_clk; end

  function automatic logic [17:0] m_en();
    logic [17:0] e;
    e[7:0]  = m_reg[0];
    e[15:8] = m_reg[1];
    e[16]   = m_reg[2][6];
    e[17]   = m_reg[2][7];
    return e;
  endfunction

  function automatic logic [17:0] m_out();
    return outs_on ? (ref_clk ? m_en() : 18'h0) : 18'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // clock-by-clock comparison against the register model
  always @(negedge clk) begin
    if (!rst && !settle && !done) begin
      chk("R8 R7 R9 outputs", 32'(clk_out), 32'(m_out()));
      chk("R9 hiz", 32'(out_hiz), outs_on ? 32'h0 : 32'h3FFFF);
    end
  end

  task automatic qw();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; qw();
    scl_drv = 1'b1; qw();
    sda_drv = 1'b0; qw();
    scl_drv = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; qw();
    scl_drv = 1'b1; qw();
    sda_drv = 1'b1; qw();
  endtask

  // slot: -1 no write, 0..2 model register, 3 discarded
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input int slot,
                           input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; qw();
      scl_drv = 1'b1; qw();
      chk("R2 no drive on data clock", 32'(sda_pull), 32'h0);
      if (i == 0 && slot >= 0 && slot < 3) settle = 1'b1;
      qw();
      scl_drv = 1'b0; qw();
    end
    sda_drv = 1'b1; qw();
    scl_drv = 1'b1; qw();
    chk(req, 32'(sda_pull), 32'(exp_ack));
    qw();
    scl_drv = 1'b0; qw();
    if (slot >= 0 && slot < 3) m_reg[slot] = b;
    settle = 1'b0;
  endtask

  task automatic check_static(input string req);
    @(negedge clk);
    while (!ref_clk) @(negedge clk);
    chk(req, 32'(clk_out), 32'(outs_on ? m_en() : 18'h0));
  endtask

  initial begin
    for (int k = 0; k < 3; k++) m_reg[k] = 8'hFF;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R6 reset hiz", 32'(out_hiz), 32'h0);
    check_static("R6 all enabled after reset");
    settle = 1'b0;

    // R1 R3 R7: ordered load, reserved bits of byte 2 cleared
    bus_start();
    send_byte(A_WR, 1'b1, -1, "R1 address ack");
    send_byte(8'h5A, 1'b1, 0, "R4 data ack byte0");
    check_static("R3 byte0 applied");
    send_byte(8'h3C, 1'b1, 1, "R4 data ack byte1");
    send_byte(8'h40, 1'b1, 2, "R4 data ack byte2");
    bus_stop();
    check_static("R7 mapping, reserved bits no effect");
    chk("R7 out17 off out16 on", 32'(clk_out[17:16]), 32'h1);

    // R4: fourth byte acknowledged and discarded
    bus_start();
    send_byte(A_WR, 1'b1, -1, "R1 address ack");
    send_byte(8'hFF, 1'b1, 0, "R4 ack");
    send_byte(8'hFF, 1'b1, 1, "R4 ack");
    send_byte(8'hC0, 1'b1, 2, "R4 ack");
    send_byte(8'h00, 1'b1, 3, "R4 fourth byte ack");
    bus_stop();
    check_static("R4 fourth byte discarded");

    // R5: repeated START and STOP both restart at byte 0
    bus_start();
    send_byte(A_WR, 1'b1, -1, "R1 address ack");
    send_byte(8'h0F, 1'b1, 0, "R4 ack");
    bus_start();
    send_byte(A_WR, 1'b1, -1, "R1 address ack after restart");
    send_byte(8'hF0, 1'b1, 0, "R4 ack");
    bus_stop();
    check_static("R5 repeated start restarts order");
    bus_start();
    send_byte(A_WR, 1'b1, -1, "R1 address ack");
    send_byte(8'h81, 1'b1, 0, "R4 ack");
    bus_stop();
    check_static("R5 stop restarts order");

    // R2: foreign address and read request
    bus_start();
    send_byte(A_BAD, 1'b0, -1, "R2 foreign address no ack");
    send_byte(8'h00, 1'b0, -1, "R2 no ack after foreign");
    bus_stop();
    check_static("R2 foreign address no effect");
    bus_start();
    send_byte(A_RD, 1'b0, -1, "R2 read request no ack");
    send_byte(8'hFF, 1'b0, -1, "R2 no data returned");
    bus_stop();
    check_static("R2 read request no effect");

    // R9: global float
    @(posedge clk); #1 outs_on = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    chk("R9 all hiz", 32'(out_hiz), 32'h3FFFF);
    check_static("R9 outputs low while floated");
    outs_on = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R9 hiz released", 32'(out_hiz), 32'h0);

    // R8: everything disabled, then reset restores R6
    bus_start();
    send_byte(A_WR, 1'b1, -1, "R1 address ack");
    send_byte(8'h00, 1'b1, 0, "R4 ack");
    send_byte(8'h00, 1'b1, 1, "R4 ack");
    send_byte(8'h00, 1'b1, 2, "R4 ack");
    bus_stop();
    check_static("R8 disabled outputs low");
    settle = 1'b1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int k = 0; k < 3; k++) m_reg[k] = 8'hFF;
    check_static("R6 reset restores enables");
    settle = 1'b0;
    repeat (40) @(posedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule